// File: doc/BRIEF.md
# Sixteen-Register Multi-Cycle Teaching Core

This block is a small processor core that runs programs written in a 16-bit instruction format. It has sixteen 16-bit general registers, a 256-word main memory and an 8-bit program counter. Each instruction takes one fetch cycle and at least one execute cycle. The core handles arithmetic, logic, shifts, immediate loads, direct and indirect memory access, conditional branches, a register jump and a jump that saves a return address.

While the core is idle after reset, a preload port writes words into memory. A one-cycle `go` pulse then starts execution at the address given on `start_pc`. The top memory address acts as a console. Reading from it takes one word from an input valid/ready stream, and the core waits until that word arrives. Writing to it puts the word on an output strobe instead of into memory. The halt instruction stops the core until the next reset, and `halted` reports this state.

Instruction layout: bits 15..12 hold the opcode and bits 11..8 hold the destination register d. In the register form, bits 7..4 hold s and bits 3..0 hold t. In the address form, bits 7..0 hold an 8-bit address or constant.

Top module: `toy16_core`

## Requirements
- R1: After reset the core is idle, with `halted`, `out_valid` and `in_ready` low. It executes nothing until `go` is pulsed. The `go` pulse loads the PC from `start_pc`.
- R2: Opcodes 1, 2, 3 and 4 write R[s]+R[t], R[s]-R[t], R[s]&R[t] and R[s]^R[t] into R[d]. Sums and differences wrap modulo 2^16.
- R3: Opcode 5 shifts R[s] left and opcode 6 shifts R[s] right arithmetically, keeping the sign bit. Both use only the low 4 bits of R[t] as the shift amount.
- R4: Opcode 7 writes the zero-extended 8-bit constant into R[d]. Opcode 8 loads R[d] from memory at the 8-bit address. Opcode 9 stores R[d] to memory at that address.
- R5: Opcode A loads R[d] from memory at the low 8 bits of R[t]. Opcode B stores R[d] there. These use the console rule when that address is 0xFF.
- R6: Register 0 always reads as zero, and any write to it is dropped.
- R7: Opcode C jumps to the address when R[d] is zero. Opcode D jumps when R[d], taken as a signed value, is greater than zero. When not taken, both fall through to the next instruction.
- R8: Opcode E jumps to the low 8 bits of R[d]. Opcode F writes the address of the next instruction into R[d] and jumps to the address field.
- R9: A load from 0xFF waits with `in_ready` low while `in_valid` is low. When `in_valid` is high, `in_ready` is high for exactly one cycle and R[d] takes `in_data`.
- R10: A store to 0xFF raises `out_valid` for exactly one cycle with R[d] on `out_data`. It does not write memory.
- R11: Opcode 0 raises `halted` until reset. While halted, the PC is frozen, there are no console transfers, and `go` and the preload port have no effect.
- R12: The preload port writes memory only while the core is idle. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Preload write enable (idle only) |
| ld_addr | input | ADDR_W | Preload word address |
| ld_data | input | DATA_W | Preload word |
| go | input | 1 | Start pulse, taken while idle |
| start_pc | input | ADDR_W | First instruction address |
| in_valid | input | 1 | Console input word available |
| in_data | input | DATA_W | Console input word |
| in_ready | output | 1 | Console input word consumed this cycle |
| out_valid | output | 1 | Console output strobe |
| out_data | output | DATA_W | Console output word |
| halted | output | 1 | Core has executed halt |

## Verification
The bench builds the core with its default parameters: 16-bit data, 8-bit addresses and sixteen registers. With these values the console sits at 0xFF and every example encoding can be used as written, including the branch to 0x29 and the link-and-jump to 0x2B. Programs are placed at several start addresses, and results are observed only through console stores. Because memory survives reset, the bench can tell whether a preload attempted while halted was really ignored.

// File: rtl/toy16_pkg.sv
package toy16_pkg;

    typedef enum logic [3:0] {
        OP_HALT = 4'h0,
        OP_ADD  = 4'h1,
        OP_SUB  = 4'h2,
        OP_AND  = 4'h3,
        OP_XOR  = 4'h4,
        OP_SHL  = 4'h5,
        OP_SHR  = 4'h6,
        OP_LIMM = 4'h7,
        OP_LD   = 4'h8,
        OP_ST   = 4'h9,
        OP_LDR  = 4'hA,
        OP_STR  = 4'hB,
        OP_BZ   = 4'hC,
        OP_BP   = 4'hD,
        OP_JR   = 4'hE,
        OP_JL   = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_HALT
    } core_state_e;

endpackage

// File: rtl/toy16_alu.sv
module toy16_alu
    import toy16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] amt;

    always_comb begin
        amt = b[SH_W-1:0];
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << amt;
            OP_SHR:  y = $unsigned($signed(a) >>> amt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/toy16_regfile.sv
module toy16_regfile #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(NREGS)-1:0] ra_d,
    input  logic [$clog2(NREGS)-1:0] ra_s,
    input  logic [$clog2(NREGS)-1:0] ra_t,
    output logic [DATA_W-1:0]        rd_d,
    output logic [DATA_W-1:0]        rd_s,
    output logic [DATA_W-1:0]        rd_t
);
    logic [DATA_W-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs_q[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (we && (int'(waddr) == g))
                    regs_q[g] <= wdata;
            end
        end
    end

    assign rd_d = regs_q[ra_d];
    assign rd_s = regs_q[ra_s];
    assign rd_t = regs_q[ra_t];
endmodule

// File: rtl/toy16_mem.sv
module toy16_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            words_q[waddr] <= wdata;
    end

    assign rdata = words_q[raddr];
endmodule

// File: rtl/toy16_core.sv
module toy16_core
    import toy16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int NREGS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);
    localparam int               RIDX_W  = $clog2(NREGS);
    localparam logic [ADDR_W-1:0] CONSOLE = '1;

    typedef struct packed {
        core_state_e       state;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
    } core_regs_t;

    core_regs_t r_q, r_d;

    opcode_e           op;
    logic [RIDX_W-1:0] fd, fs, ft;
    logic [ADDR_W-1:0] imm, ea;
    logic [DATA_W-1:0] rd_v, rs_v, rt_v, alu_y, mem_rdata;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;
    logic              core_mem_we;
    logic [ADDR_W-1:0] mem_raddr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] pc_q;

    assign op  = opcode_e'(r_q.ir[15:12]);
    assign fd  = r_q.ir[8 +: RIDX_W];
    assign fs  = r_q.ir[4 +: RIDX_W];
    assign ft  = r_q.ir[0 +: RIDX_W];
    assign imm = r_q.ir[ADDR_W-1:0];
    assign ea  = (op == OP_LDR || op == OP_STR) ? rt_v[ADDR_W-1:0] : imm;

    toy16_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (fd),
        .wdata (rf_wdata),
        .ra_d  (fd),
        .ra_s  (fs),
        .ra_t  (ft),
        .rd_d  (rd_v),
        .rd_s  (rs_v),
        .rd_t  (rt_v)
    );

    toy16_alu #(.DATA_W(DATA_W)) u_alu (
        .op (op),
        .a  (rs_v),
        .b  (rt_v),
        .y  (alu_y)
    );

    assign mem_raddr = (r_q.state == ST_FETCH) ? r_q.pc : ea;
    assign mem_we    = (r_q.state == ST_IDLE) ? ld_we   : core_mem_we;
    assign mem_waddr = (r_q.state == ST_IDLE) ? ld_addr : ea;
    assign mem_wdata = (r_q.state == ST_IDLE) ? ld_data : rd_v;

    toy16_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        r_d         = r_q;
        rf_we       = 1'b0;
        rf_wdata    = '0;
        core_mem_we = 1'b0;
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_data    = rd_v;
        unique case (r_q.state)
            ST_IDLE: begin
                if (go) begin
                    r_d.pc    = start_pc;
                    r_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.ir    = mem_rdata;
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.state = ST_FETCH;
                unique case (op)
                    OP_HALT: r_d.state = ST_HALT;
                    OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: begin
                        rf_we    = 1'b1;
                        rf_wdata = alu_y;
                    end
                    OP_LIMM: begin
                        rf_we    = 1'b1;
                        rf_wdata = DATA_W'(imm);
                    end
                    OP_LD, OP_LDR: begin
                        if (ea == CONSOLE) begin
                            if (in_valid) begin
                                in_ready = 1'b1;
                                rf_we    = 1'b1;
                                rf_wdata = in_data;
                            end else begin
                                r_d.state = ST_EXEC;
                            end
                        end else begin
                            rf_we    = 1'b1;
                            rf_wdata = mem_rdata;
                        end
                    end
                    OP_ST, OP_STR: begin
                        if (ea == CONSOLE)
                            out_valid = 1'b1;
                        else
                            core_mem_we = 1'b1;
                    end
                    OP_BZ: begin
                        if (rd_v == '0)
                            r_d.pc = imm;
                    end
                    OP_BP: begin
                        if (!rd_v[DATA_W-1] && (rd_v != '0))
                            r_d.pc = imm;
                    end
                    OP_JR: r_d.pc = rd_v[ADDR_W-1:0];
                    OP_JL: begin
                        rf_we    = 1'b1;
                        rf_wdata = DATA_W'(r_q.pc);
                        r_d.pc   = imm;
                    end
                    default: ;
                endcase
            end
            ST_HALT: ;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.pc    <= '0;
            r_q.ir    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_q   = r_q.pc;
    assign halted = (r_q.state == ST_HALT);
endmodule

// File: rtl/toy16_core_chk.sv
module toy16_core_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_q
);
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);

    a_r9_ready_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    a_r10_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r10_no_mixed_console: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r11_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_q));

    a_r11_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_valid && !in_ready));
endmodule

bind toy16_core toy16_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .halted    (halted),
    .pc_q      (pc_q)
);

// File: tb/toy16_core_test.sv
module toy16_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        go = 1'b0;
    logic [7:0]  start_pc = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, halted;
    logic [15:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int outn = 0;
    int rdy_cnt = 0;
    logic [15:0] obuf [16];

    always #2.5 clk = ~clk;

    toy16_core uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .go(go), .start_pc(start_pc), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .halted(halted)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (outn < 16) obuf[outn] = out_data;
            outn = outn + 1;
        end
        if (rst_n && in_ready) rdy_cnt = rdy_cnt + 1;
    end

    // {opcode, a, b, expected}
    localparam int NV = 11;
    localparam logic [51:0] VEC [NV] = '{
        {4'h1, 16'h1234, 16'h0FF0, 16'h2224},
        {4'h1, 16'hFFFF, 16'h0001, 16'h0000},
        {4'h2, 16'h0005, 16'h0007, 16'hFFFE},
        {4'h3, 16'hF0F0, 16'h3C3C, 16'h3030},
        {4'h4, 16'hF0F0, 16'h3C3C, 16'hCCCC},
        {4'h5, 16'h0003, 16'h0004, 16'h0030},
        {4'h5, 16'h0001, 16'h0011, 16'h0002},
        {4'h5, 16'h8001, 16'h000F, 16'h8000},
        {4'h6, 16'h8000, 16'h0004, 16'hF800},
        {4'h6, 16'h7F00, 16'h0008, 16'h007F},
        {4'h6, 16'h1234, 16'h0010, 16'h1234}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic expect_out(input string req, input int idx, input logic [15:0] exp);
        check(req, (idx < outn && idx < 16) ? obuf[idx] : 16'hxxxx, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ld_we = 1'b0; go = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        outn = 0;
        rdy_cnt = 0;
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic launch(input logic [7:0] pc);
        start_pc = pc; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " halt reached"}, {15'd0, halted}, 16'd1);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state and idle until go
        do_reset();
        repeat (5) @(negedge clk);
        check("R1 halted after reset", {15'd0, halted}, 16'd0);
        check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
        check("R1 in_ready after reset", {15'd0, in_ready}, 16'd0);
        check("R1 no output before go", 16'(outn), 16'd0);

        // R2 R3: table of ALU vectors
        for (int i = 0; i < NV; i++) begin
            do_reset();
            poke(8'h00, 16'h8110);
            poke(8'h01, 16'h8211);
            poke(8'h02, {VEC[i][51:48], 12'h312});
            poke(8'h03, 16'h93FF);
            poke(8'h04, 16'h0000);
            poke(8'h10, VEC[i][47:32]);
            poke(8'h11, VEC[i][31:16]);
            launch(8'h00);
            wait_halt("R2/R3 vector");
            expect_out((VEC[i][51:48] >= 4'h5) ? "R3 shift vector" : "R2 alu vector", 0, VEC[i][15:0]);
            check("R2/R3 one output", 16'(outn), 16'd1);
        end

        // R4 R2: example encodings 7101 and 12AC
        do_reset();
        poke(8'h00, 16'h7101); poke(8'h01, 16'h91FF);
        poke(8'h02, 16'h7A05); poke(8'h03, 16'h7C07);
        poke(8'h04, 16'h12AC); poke(8'h05, 16'h92FF); poke(8'h06, 16'h0000);
        launch(8'h00);
        wait_halt("R4");
        expect_out("R4 limm 7101", 0, 16'h0001);
        expect_out("R2 add 12AC", 1, 16'h000C);

        // R6: register 0 stays zero
        do_reset();
        poke(8'h00, 16'h7005); poke(8'h01, 16'h90FF); poke(8'h02, 16'h0000);
        launch(8'h00);
        wait_halt("R6");
        expect_out("R6 r0 reads zero", 0, 16'h0000);

        // R4: direct store then load
        do_reset();
        poke(8'h00, 16'h7155); poke(8'h01, 16'h9140); poke(8'h02, 16'h8240);
        poke(8'h03, 16'h92FF); poke(8'h04, 16'h0000);
        launch(8'h00);
        wait_halt("R4");
        expect_out("R4 direct store/load", 0, 16'h0055);
        check("R4 store to memory no strobe", 16'(outn), 16'd1);

        // R5: indirect access, including console via R[t]
        do_reset();
        poke(8'h00, 16'h7142); poke(8'h01, 16'h72AB); poke(8'h02, 16'hB201);
        poke(8'h03, 16'hA301); poke(8'h04, 16'h93FF); poke(8'h05, 16'h71FF);
        poke(8'h06, 16'h74CD); poke(8'h07, 16'hB401); poke(8'h08, 16'h0000);
        launch(8'h00);
        wait_halt("R5");
        expect_out("R5 indirect store/load", 0, 16'h00AB);
        expect_out("R5 indirect console store", 1, 16'h00CD);

        // R7 R12: branch if zero taken (CD29), start at 0x20
        do_reset();
        poke(8'h20, 16'h7D00); poke(8'h21, 16'hCD29); poke(8'h22, 16'h71EE);
        poke(8'h23, 16'h91FF); poke(8'h24, 16'h0000);
        poke(8'h29, 16'h7177); poke(8'h2A, 16'h91FF); poke(8'h2B, 16'h0000);
        launch(8'h20);
        wait_halt("R7");
        expect_out("R7 R12 bz taken", 0, 16'h0077);
        check("R7 bz taken count", 16'(outn), 16'd1);

        // R7: branch if zero not taken
        do_reset();
        poke(8'h20, 16'h7D03);
        launch(8'h20);
        wait_halt("R7");
        expect_out("R7 bz not taken", 0, 16'h00EE);

        // R7: branch if positive, signed
        do_reset();
        poke(8'h50, 16'h8000);
        poke(8'h00, 16'h8150); poke(8'h01, 16'hD104); poke(8'h02, 16'h7211);
        poke(8'h03, 16'h92FF); poke(8'h04, 16'h7300); poke(8'h05, 16'hD308);
        poke(8'h06, 16'h7222); poke(8'h07, 16'h92FF); poke(8'h08, 16'h7301);
        poke(8'h09, 16'hD30C); poke(8'h0A, 16'h7233); poke(8'h0B, 16'h92FF);
        poke(8'h0C, 16'h7244); poke(8'h0D, 16'h92FF); poke(8'h0E, 16'h0000);
        launch(8'h00);
        wait_halt("R7");
        expect_out("R7 bp 0x8000 not taken", 0, 16'h0011);
        expect_out("R7 bp zero not taken", 1, 16'h0022);
        expect_out("R7 bp one taken", 2, 16'h0044);
        check("R7 bp output count", 16'(outn), 16'd3);

        // R8: jump and link FF2B, then jump register
        do_reset();
        poke(8'h10, 16'hFF2B);
        poke(8'h2B, 16'h9FFF); poke(8'h2C, 16'h7E30); poke(8'h2D, 16'hEE00);
        poke(8'h2E, 16'h71BB); poke(8'h2F, 16'h91FF);
        poke(8'h30, 16'h71CC); poke(8'h31, 16'h91FF); poke(8'h32, 16'h0000);
        launch(8'h10);
        wait_halt("R8");
        expect_out("R8 link value", 0, 16'h0011);
        expect_out("R8 jr target", 1, 16'h00CC);
        check("R8 output count", 16'(outn), 16'd2);

        // R9: console input stall and handshake
        do_reset();
        poke(8'h00, 16'h81FF); poke(8'h01, 16'h91FF); poke(8'h02, 16'h0000);
        launch(8'h00);
        repeat (6) @(negedge clk);
        check("R9 stall no ready", 16'(rdy_cnt), 16'd0);
        check("R9 stall not halted", {15'd0, halted}, 16'd0);
        @(posedge clk);
        #1;
        in_data = 16'hBEEF; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        wait_halt("R9");
        check("R9 one ready pulse", 16'(rdy_cnt), 16'd1);
        expect_out("R9 R10 echo", 0, 16'hBEEF);

        // R11 R12: halt sticky, go and preload ignored while halted
        do_reset();
        poke(8'h00, 16'h7155); poke(8'h01, 16'h91FF); poke(8'h02, 16'h0000);
        launch(8'h00);
        wait_halt("R11");
        repeat (10) @(negedge clk);
        poke(8'h00, 16'h7166);
        launch(8'h00);
        repeat (10) @(negedge clk);
        check("R11 still halted", {15'd0, halted}, 16'd1);
        check("R11 no output after halt", 16'(outn), 16'd1);
        do_reset();
        launch(8'h00);
        wait_halt("R12");
        expect_out("R12 preload while halted ignored", 0, 16'h0055);

        summary();
        $finish;
    end
endmodule